// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Instruction Cache

This block is a read-only instruction cache. It sits between an instruction fetch unit and a 32-bit memory read port. It is direct-mapped, and its capacity is a parameter between 1 KB and 16 KB. Each 32-byte line holds eight 32-bit words. Every word keeps its own valid bit, and all eight words of a line share one tag. When the fetch address finds a valid word with a matching tag, the word is returned combinationally in the same cycle as the request.

On a miss the fetch unit holds its request and waits. The cache asks memory for the missing word only. It forwards that word to the fetch port in the cycle it arrives, and stores it. It then requests the word that follows, unless the missed word is the last one in its line. That second fill runs in the background, and hits are served while it is outstanding.

An invalidate input clears every valid bit by sweeping the lines, one line per clock. The same sweep runs after reset. No fetch is answered while an invalidate is pending or the sweep is in progress.

Top module: `icache_subblk`

## Requirements
- R1: A fetch whose word is valid under a matching tag sees `fetch_valid` high in the same cycle, with `fetch_data` holding that word.
- R2: On a miss, the cache raises `mem_req` with `mem_addr` set to the word address (bits [1:0] zero). It forwards `mem_rdata` to the fetch port in the cycle `mem_rvalid` is high, and stores the word.
- R3: `mem_req` stays high and `mem_addr` stays unchanged until the cycle `mem_rvalid` is high.
- R4: After a demand word at word offset 0 to 6 (address bits [4:2]), the next memory request is for that address plus 4. The word it returns is stored and then hits.
- R5: A demand word at offset 7 causes no further request, and no word of the following line becomes valid.
- R6: A hit is answered in zero cycles while the background fill is still outstanding.
- R7: A fill makes valid only the demanded word and its follower. The other words of the same line still miss.
- R8: The line is selected by address bits [5+IDX_W-1:5], where IDX_W = log2(CACHE_BYTES/32). A fill whose tag differs from the stored one invalidates every other word of that line.
- R9: An `inv_all` pulse, and reset, start a sweep that clears one line per cycle over CACHE_BYTES/32 cycles. No fetch is answered during the sweep or while it is pending, and every word misses afterwards.
- R10: Fetch address bits [1:0] are ignored. Any byte address within a word returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_req | input | 1 | Fetch request; held until `fetch_valid` is seen |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_valid | output | 1 | Fetch answered in this cycle |
| fetch_data | output | 32 | Instruction word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word-aligned byte address |
| mem_rvalid | input | 1 | Memory read data valid (one-cycle pulse) |
| mem_rdata | input | 32 | Memory read data |
| inv_all | input | 1 | Invalidate every word |

## Verification
The following properties are checked on every cycle:
- the memory request is held steady until it is answered;
- the background request always targets the next word and never wraps past offset 7;
- the sweep counter advances by one line per cycle;
- a swept line is empty afterwards;
- a retagging fill leaves exactly one valid word in the line;
- no fetch is answered during the sweep.

Several behaviours show only in the bench scenarios:
- the zero-cycle hit, including a hit during the background fill;
- the miss on the word two past a fill;
- the miss on an old tag after a conflicting fill;
- the wait of a full sweep after an invalidate;
- that the byte offset has no effect.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int LINE_WORDS = 8;
  localparam int OFF_W      = 3;
  localparam int LINE_SHIFT = 5;
  typedef enum logic [1:0] {ST_IDLE, ST_DEMAND, ST_BGFILL, ST_SWEEP} ic_state_e;
endpackage

// File: rtl/icache_lines.sv
module icache_lines #(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              lk_idx,
  input  logic [icache_pkg::OFF_W-1:0]  lk_off,
  input  logic [TAG_W-1:0]              lk_tag,
  output logic                          lk_hit,
  output logic [DATA_W-1:0]             lk_data,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [icache_pkg::OFF_W-1:0]  wr_off,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          clr_en,
  input  logic [IDX_W-1:0]              clr_idx
);
  import icache_pkg::*;
  localparam int NUM_LINES = 1 << IDX_W;
  localparam int NUM_WORDS = NUM_LINES * LINE_WORDS;

  logic [TAG_W-1:0]      tag_q [NUM_LINES];
  logic [LINE_WORDS-1:0] vld_q [NUM_LINES];
  logic [DATA_W-1:0]     dat_q [NUM_WORDS];

  logic [LINE_WORDS-1:0] line_vld_d;
  logic                  same_tag;

  // Next valid vector of the line being written: a retag drops the others.
  always_comb begin
    same_tag   = (tag_q[wr_idx] == wr_tag);
    line_vld_d = LINE_WORDS'(1) << wr_off;
    if (same_tag) line_vld_d = line_vld_d | vld_q[wr_idx];
  end

  always_ff @(posedge clk) begin
    if (clr_en) begin
      vld_q[clr_idx] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= line_vld_d;
      tag_q[wr_idx] <= wr_tag;
    end
    if (wr_en) dat_q[{wr_idx, wr_off}] <= wr_data;
  end

  assign lk_hit  = vld_q[lk_idx][lk_off] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = dat_q[{lk_idx, lk_off}];

  p_swept_line_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (vld_q[$past(clr_idx)] == '0));

  p_retag_single_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en && (tag_q[wr_idx] != wr_tag))
      |=> ($countones(vld_q[$past(wr_idx)]) == 1));
endmodule

// File: rtl/icache_fsm.sv
module icache_fsm #(
  parameter int WADDR_W = 30,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic [WADDR_W-1:0] fetch_waddr,
  input  logic               lk_hit,
  input  logic               inv_all,
  input  logic               mem_rvalid,
  output logic               mem_req,
  output logic [WADDR_W-1:0] req_waddr,
  output logic               wr_en,
  output logic               clr_en,
  output logic [IDX_W-1:0]   clr_idx,
  output logic               serve_ok,
  output logic               fwd_ok
);
  import icache_pkg::*;

  ic_state_e          state_q, state_d;
  logic [WADDR_W-1:0] waddr_q, waddr_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic               pend_q, pend_d;
  logic               inv_seen;

  assign inv_seen = pend_q | inv_all;

  always_comb begin
    state_d = state_q;
    waddr_d = waddr_q;
    cnt_d   = cnt_q;
    pend_d  = inv_seen;
    unique case (state_q)
      ST_IDLE: begin
        if (inv_seen) begin
          state_d = ST_SWEEP;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end else if (fetch_req && !lk_hit) begin
          state_d = ST_DEMAND;
          waddr_d = fetch_waddr;
        end
      end
      ST_DEMAND: begin
        if (mem_rvalid) begin
          if (inv_seen) begin
            state_d = ST_SWEEP;
            cnt_d   = '0;
            pend_d  = 1'b0;
          end else if (waddr_q[OFF_W-1:0] != 3'd7) begin
            state_d = ST_BGFILL;
            waddr_d = waddr_q + 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BGFILL: begin
        if (mem_rvalid) begin
          if (inv_seen) begin
            state_d = ST_SWEEP;
            cnt_d   = '0;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == '1) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SWEEP;
      waddr_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      waddr_q <= waddr_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign mem_req   = (state_q == ST_DEMAND) || (state_q == ST_BGFILL);
  assign req_waddr = waddr_q;
  assign wr_en     = mem_req && mem_rvalid;
  assign clr_en    = (state_q == ST_SWEEP);
  assign clr_idx   = cnt_q;
  assign serve_ok  = !inv_seen && (state_q != ST_SWEEP);
  assign fwd_ok    = !inv_seen && (state_q == ST_DEMAND) && mem_rvalid
                     && (fetch_waddr == waddr_q);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(waddr_q)));

  p_bgfill_next_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DEMAND) && mem_rvalid && !inv_seen && (waddr_q[OFF_W-1:0] != 3'd7))
      |=> ((state_q == ST_BGFILL) && (waddr_q == $past(waddr_q) + 1'b1)));

  p_bgfill_in_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BGFILL) |-> (waddr_q[OFF_W-1:0] != 3'd0));

  p_sweep_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SWEEP) && (cnt_q != '1))
      |=> ((state_q == ST_SWEEP) && (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/icache_subblk.sv
module icache_subblk #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [31:0]       fetch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              inv_all
);
  import icache_pkg::*;
  localparam int NUM_LINES = CACHE_BYTES / (LINE_WORDS * 4);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = ADDR_W - LINE_SHIFT - IDX_W;
  localparam int WADDR_W   = ADDR_W - 2;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [WADDR_W-1:0] fetch_waddr, req_waddr;
  logic               lk_hit, wr_en, clr_en, serve_ok, fwd_ok;
  logic [IDX_W-1:0]   clr_idx;
  logic [31:0]        lk_data;
  logic               unused_byte_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign fetch_waddr      = fetch_addr[ADDR_W-1:2];
  assign unused_byte_bits = ^fetch_addr[1:0];

  icache_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(32)) u_lines (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lk_idx  (fetch_waddr[OFF_W +: IDX_W]),
    .lk_off  (fetch_waddr[OFF_W-1:0]),
    .lk_tag  (fetch_waddr[WADDR_W-1 -: TAG_W]),
    .lk_hit  (lk_hit),
    .lk_data (lk_data),
    .wr_en   (wr_en),
    .wr_idx  (req_waddr[OFF_W +: IDX_W]),
    .wr_off  (req_waddr[OFF_W-1:0]),
    .wr_tag  (req_waddr[WADDR_W-1 -: TAG_W]),
    .wr_data (mem_rdata),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  icache_fsm #(.WADDR_W(WADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fetch_req   (fetch_req),
    .fetch_waddr (fetch_waddr),
    .lk_hit      (lk_hit),
    .inv_all     (inv_all),
    .mem_rvalid  (mem_rvalid),
    .mem_req     (mem_req),
    .req_waddr   (req_waddr),
    .wr_en       (wr_en),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .serve_ok    (serve_ok),
    .fwd_ok      (fwd_ok)
  );

  assign fetch_valid = fetch_req && ((serve_ok && lk_hit) || fwd_ok);
  assign fetch_data  = fwd_ok ? mem_rdata : lk_data;
  assign mem_addr    = {req_waddr, 2'b00};

  p_no_answer_in_sweep_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_en |-> !fetch_valid);
endmodule

// File: tb/icache_subblk_tb.sv
module icache_subblk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CB         = 1024;
  localparam int NL         = CB / 32;
  localparam int LAT        = 4;

  logic        clk = 1'b0;
  logic        rst_n, fetch_req, inv_all, mem_rvalid;
  logic [31:0] fetch_addr, fetch_data, mem_addr, mem_rdata;
  logic        fetch_valid, mem_req;

  int total = 0, fails = 0;
  int mcnt;
  int unsigned log_a [0:4095];
  int log_n = 0;
  int unsigned ref_tag [NL];
  bit [7:0]    ref_vld [NL];

  icache_subblk #(.ADDR_W(32), .CACHE_BYTES(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .inv_all(inv_all)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a >> 2) * 32'h9E3779B1 ^ 32'h3C3C5A5A;
  endfunction

  // Memory model: answers a held request after LAT cycles.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; mcnt <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (mcnt == LAT - 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(mem_addr);
        mcnt       <= 0;
        if (log_n < 4096) log_a[log_n] = mem_addr;
        log_n = log_n + 1;
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int line_of(input logic [31:0] a); return (a >> 5) % NL; endfunction
  function automatic int unsigned tag_of(input logic [31:0] a); return (a >> 5) / NL; endfunction
  function automatic bit ref_hit(input logic [31:0] a);
    return ref_vld[line_of(a)][a[4:2]] && (ref_tag[line_of(a)] == tag_of(a));
  endfunction
  task automatic ref_fill(input logic [31:0] a);
    int l = line_of(a);
    if (ref_tag[l] != tag_of(a)) begin
      ref_vld[l] = 8'h00; ref_tag[l] = tag_of(a);
    end
    ref_vld[l][a[4:2]] = 1'b1;
  endtask
  task automatic ref_miss(input logic [31:0] a);
    ref_fill(a);
    if (a[4:2] != 3'd7) ref_fill(a + 4);
  endtask
  task automatic ref_clear();
    for (int i = 0; i < NL; i++) ref_vld[i] = 8'h00;
  endtask

  task automatic fetch(input logic [31:0] a, output int waits, output logic [31:0] d);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a; waits = 0;
    #1;
    while (!fetch_valid && waits < 3000) begin
      @(negedge clk); #1; waits++;
    end
    d = fetch_data;
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    ref_clear();
  endtask

  // Fetch and check data and hit/miss against an explicit expectation.
  task automatic chk_fetch(input logic [31:0] a, input bit exp_hit, input string req);
    int w; logic [31:0] d;
    fetch(a, w, d);
    check(d == mem_word(a), req, d, mem_word(a));
    check((w == 0) == exp_hit, req, w, exp_hit ? 0 : LAT);
    if (!exp_hit) ref_miss(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, w, ln;
    bit early;
    logic [31:0] d, a;
    void'($urandom(32'h1CAC4E));
    for (int i = 0; i < NL; i++) begin ref_tag[i] = 0; ref_vld[i] = 8'h00; end
    rst_n = 1'b0; fetch_req = 1'b1; fetch_addr = 32'h100; inv_all = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!fetch_valid && !mem_req, "R9 reset state", {fetch_valid, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R9: post-reset sweep stalls the held request for at least NL cycles
    n = 0; early = 1'b0;
    while (!mem_req && n < NL + 50) begin
      @(negedge clk); #1; n++;
      if (fetch_valid) early = 1'b1;
    end
    check(n >= NL && !early, "R9 reset sweep", n, NL);
    while (!fetch_valid) begin @(negedge clk); #1; end
    check(fetch_data == mem_word(32'h100), "R2 forwarded word", fetch_data, mem_word(32'h100));
    @(posedge clk); #1; fetch_req = 1'b0;
    ref_miss(32'h100);
    drain();
    // R2 R3 R4: request addresses seen by memory
    check(log_a[0] == 32'h100, "R2 demand address", log_a[0], 32'h100);
    check(log_a[1] == 32'h104 && log_n == 2, "R4 next-word request", log_a[1], 32'h104);
    chk_fetch(32'h104, 1'b1, "R1 R4 stored next word hits");
    chk_fetch(32'h108, 1'b0, "R7 word two past misses");
    drain();
    // R5: last word of a line, no crossing
    ln = log_n;
    chk_fetch(32'h11C, 1'b0, "R5 offset 7 miss");
    drain();
    check(log_n == ln + 1, "R5 single request", log_n - ln, 1);
    chk_fetch(32'h120, 1'b0, "R5 next line untouched");
    drain();
    // R6: hit while background fill outstanding
    chk_fetch(32'h200, 1'b0, "R6 setup miss");
    check(mem_req == 1'b1, "R6 fill outstanding", mem_req, 1);
    chk_fetch(32'h104, 1'b1, "R6 hit during fill");
    drain();
    // R10: byte offset ignored
    chk_fetch(32'h102, 1'b1, "R10 byte offset");
    // R8: retag invalidates other words of the line
    chk_fetch(32'h140, 1'b0, "R8 setup");
    drain();
    chk_fetch(32'h148 + CB, 1'b0, "R8 conflicting tag miss");
    drain();
    chk_fetch(32'h140, 1'b0, "R8 old tag evicted");
    drain();
    // R9: invalidate
    pulse_inv();
    fetch(32'h104, w, d);
    check(w >= NL, "R9 stall during sweep", w, NL);
    check(d == mem_word(32'h104), "R9 data after sweep", d, mem_word(32'h104));
    ref_miss(32'h104);
    drain();
    // Random traffic against the reference model (R1 R2 R7 R8 R10)
    for (int k = 0; k < 400; k++) begin
      a = ($urandom % (3 * CB)) & 32'hFFFF_FFFF;
      if ($urandom % 60 == 0) pulse_inv();
      chk_fetch(a, ref_hit(a), "R1 R2 R7 R8 R10 random");
      drain();
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule